// File: doc/BRIEF.md
# Serial ADC Read Master

This block is the host side of a three-wire link to a 12-bit successive-approximation converter. The link uses clock polarity 0 and phase 0. When a start request arrives and the block is idle, it drops chip select while the serial clock stays low. It then waits for the converter to finish: either it watches the data line for a low-to-high edge, bounded by a timeout, or it waits a fixed worst-case conversion interval. Once the wait ends it generates the serial clock from a divided system clock and samples the data line on each rising clock edge.

The received stream starts with a marker bit that is always 1, followed by the result MSB first. The block drops the marker and presents the 12-bit result with a one-cycle valid strobe. It offers two framings:
- A 13-clock continuous read.
- A 16-clock framing built from two 8-bit bytes, in which the marker and the three padding zeros are checked.

All serial timing is given in nanoseconds and converted into system-clock counts that are rounded up. This guarantees the minimum clock phase width, the minimum chip-select high time and the post-abort acquisition time.

Top module: `adc_reader`

## Requirements
- R1: After reset, csN is 1, sclk is 0, busy is 0, and resultValid, frameErr and timeoutErr are 0.
- R2: start is accepted only while busy is 0. On acceptance csN falls while sclk is low. A start pulse seen while busy is 1 is ignored: each transaction produces exactly one csN falling edge.
- R3: With pollEoc=1, no sclk edge occurs until the data line has risen after csN fell. Clocking then begins within a few system cycles plus one clock half-period.
- R4: With pollEoc=0, the first sclk rising edge comes no earlier than the rounded-up conversion interval after csN fell.
- R5: Every sclk high phase and every sclk low phase lasts at least the rounded-up half-period count of system cycles.
- R6: With byteMode=0, exactly 13 sclk rising edges are issued. The first sampled bit is dropped as the marker, and result holds the next 12 bits, first-received bit in bit 11.
- R7: With byteMode=1, exactly 16 sclk rising edges are issued. Sampled bit 0 is the marker, bits 1 to 12 become result[11:0] MSB first, and bits 13 to 15 are padding.
- R8: In byteMode=1, frameErr pulses together with resultValid when the marker is 0 or any padding bit is 1. The result is still delivered. In byteMode=0, frameErr stays 0.
- R9: csN rises only while sclk has been low since the final falling edge. sclk never toggles while csN is high. csN then stays high for at least the rounded-up chip-select high time before the next fall.
- R10: With pollEoc=1, if no rising data edge arrives within the timeout, the following happen:
  - csN rises and timeoutErr pulses for one cycle.
  - resultValid does not pulse and no sclk edge is produced.
  - busy holds until csN has been high for at least the rounded-up acquisition time.
- R11: resultValid is a one-cycle pulse, issued once per completed transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a conversion and read (ignored while busy) |
| byteMode | input | 1 | 0: 13-clock framing, 1: 16-clock two-byte framing |
| pollEoc | input | 1 | 1: wait for a data-line rise with timeout, 0: wait the fixed conversion interval |
| miso | input | 1 | Serial data from the converter |
| sclk | output | 1 | Serial clock, idles low |
| csN | output | 1 | Active-low chip select |
| busy | output | 1 | Transaction or guard interval in progress |
| result | output | 12 | Last conversion result |
| resultValid | output | 1 | One-cycle strobe when result updates |
| frameErr | output | 1 | One-cycle strobe: bad marker or padding in byte framing |
| timeoutErr | output | 1 | One-cycle strobe: end of conversion never signalled |

## Verification
The bench goes after four kinds of corner case.
- **Early clocking.** The modelled converter flags any sclk edge seen before it has raised its data line. A reader that ignored the end-of-conversion edge would clock early and read the marker slot as a data bit. A reader that always waited the full interval would miss the latency bound.
- **Framing-specific checks.** Bad padding is injected in both framings. A marker of 0 is forced in fixed-wait byte mode. Checking in the wrong framing, or taking the result from the wrong bit slice, shows up as a wrong result or a wrong frameErr.
- **Timeout recovery.** After a timeout, the bench starts the next transaction the moment busy falls. A guard that reused the short chip-select time would give a high interval below the acquisition time.
- **Start while busy.** Start pulses arrive in the middle of a conversion. A second chip-select fall or a second valid strobe shows that the request was not ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONV,
    ST_SHIFT,
    ST_TAIL,
    ST_GUARD
  } rdState_t;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic clear;    // new transaction accepted: reset frame, latch framing
    logic capture;  // sclk rising now: shift in one sampled bit
    logic finish;   // frame complete: publish result and checks
  } rdStrobe_t;

  function automatic int unsigned cdivU(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned maxU(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned HALF_CYC    = 60,
  parameter int unsigned CONV_CYC    = 1875,
  parameter int unsigned TIMEOUT_CYC = 2500,
  parameter int unsigned GUARD_CYC   = 60,
  parameter int unsigned ACQ_CYC     = 375
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      pollEoc,
  input  logic      eocRise,
  input  logic      lastBit,
  output rdStrobe_t strobe,
  output logic      sclk,
  output logic      csN,
  output logic      busy,
  output logic      timeoutErr
);

  localparam int unsigned MAX_WAIT = maxU(maxU(CONV_CYC, TIMEOUT_CYC), maxU(ACQ_CYC, maxU(HALF_CYC, GUARD_CYC)));
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  localparam cnt_t HALF_LAST  = cnt_t'(HALF_CYC - 1);
  localparam cnt_t CONV_LAST  = cnt_t'(CONV_CYC - 1);
  localparam cnt_t TO_LAST    = cnt_t'(TIMEOUT_CYC - 1);
  localparam cnt_t GUARD_LAST = cnt_t'(GUARD_CYC - 1);
  localparam cnt_t ACQ_LAST   = cnt_t'(ACQ_CYC - 1);

  rdState_t state, stateNx;
  cnt_t     cnt, cntNx;
  logic     sclkQ, sclkNx;
  logic     csNQ, csNNx;
  logic     pollQ, pollNx;
  logic     acqQ, acqNx;
  logic     toQ, toNx;

  always_comb begin
    stateNx = state;
    cntNx   = cnt + cnt_t'(1);
    sclkNx  = sclkQ;
    csNNx   = csNQ;
    pollNx  = pollQ;
    acqNx   = acqQ;
    toNx    = 1'b0;
    strobe  = '0;
    unique case (state)
      ST_IDLE: begin
        cntNx = '0;
        if (start) begin
          strobe.clear = 1'b1;
          csNNx        = 1'b0;
          pollNx       = pollEoc;
          stateNx      = ST_CONV;
        end
      end
      ST_CONV: begin
        if (pollQ && eocRise) begin
          cntNx   = '0;
          stateNx = ST_SHIFT;
        end else if (pollQ && (cnt == TO_LAST)) begin
          cntNx   = '0;
          csNNx   = 1'b1;
          toNx    = 1'b1;
          acqNx   = 1'b1;
          stateNx = ST_GUARD;
        end else if (!pollQ && (cnt == CONV_LAST)) begin
          cntNx   = '0;
          stateNx = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (cnt == HALF_LAST) begin
          cntNx = '0;
          if (!sclkQ) begin
            sclkNx         = 1'b1;
            strobe.capture = 1'b1;
          end else begin
            sclkNx = 1'b0;
            if (lastBit) stateNx = ST_TAIL;
          end
        end
      end
      ST_TAIL: begin
        if (cnt == HALF_LAST) begin
          cntNx         = '0;
          csNNx         = 1'b1;
          acqNx         = 1'b0;
          strobe.finish = 1'b1;
          stateNx       = ST_GUARD;
        end
      end
      ST_GUARD: begin
        if (cnt == (acqQ ? ACQ_LAST : GUARD_LAST)) begin
          cntNx   = '0;
          stateNx = ST_IDLE;
        end
      end
      default: begin
        cntNx   = '0;
        stateNx = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      sclkQ <= 1'b0;
      csNQ  <= 1'b1;
      pollQ <= 1'b0;
      acqQ  <= 1'b0;
      toQ   <= 1'b0;
    end else begin
      state <= stateNx;
      cnt   <= cntNx;
      sclkQ <= sclkNx;
      csNQ  <= csNNx;
      pollQ <= pollNx;
      acqQ  <= acqNx;
      toQ   <= toNx;
    end
  end

  assign sclk       = sclkQ;
  assign csN        = csNQ;
  assign timeoutErr = toQ;
  assign busy       = (state != ST_IDLE);

endmodule

// File: rtl/adc_rd_datapath.sv
module adc_rd_datapath
  import adc_rd_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned BYTE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              miso,
  input  logic              byteMode,
  input  rdStrobe_t         strobe,
  output logic              eocRise,
  output logic              lastBit,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              frameErr
);

  localparam int unsigned CONT_W  = DATA_W + 1;
  localparam int unsigned FRAME_W = cdivU(CONT_W, BYTE_W) * BYTE_W;
  localparam int unsigned PAD_W   = FRAME_W - CONT_W;
  localparam int unsigned BC_W    = $clog2(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   misoPrev;
  logic                   bitNow;
  logic [FRAME_W-1:0]     frameQ;
  logic [BC_W-1:0]        bitCnt;
  logic                   modeQ;
  logic                   padBad;

  // Resynchronise the converter's data line; idle level is high
  generate
    if (SYNC_STAGES > 1) begin : g_sync_chain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], miso};
      end
    end else begin : g_sync_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= miso;
      end
    end
  endgenerate

  assign bitNow  = syncQ[SYNC_STAGES-1];
  assign eocRise = bitNow & ~misoPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) misoPrev <= 1'b1;
    else       misoPrev <= bitNow;
  end

  // Padding check exists only when the byte framing has spare slots
  generate
    if (PAD_W > 0) begin : g_pad
      assign padBad = |frameQ[PAD_W-1:0];
    end else begin : g_nopad
      assign padBad = 1'b0;
    end
  endgenerate

  assign lastBit = (bitCnt == (modeQ ? BC_W'(FRAME_W) : BC_W'(CONT_W)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameQ <= '0;
      bitCnt <= '0;
      modeQ  <= 1'b0;
    end else if (strobe.clear) begin
      frameQ <= '0;
      bitCnt <= '0;
      modeQ  <= byteMode;
    end else if (strobe.capture) begin
      frameQ <= {frameQ[FRAME_W-2:0], bitNow};
      bitCnt <= bitCnt + BC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      result      <= '0;
      resultValid <= 1'b0;
      frameErr    <= 1'b0;
    end else begin
      resultValid <= strobe.finish;
      frameErr    <= strobe.finish & modeQ & (~frameQ[FRAME_W-1] | padBad);
      if (strobe.finish) begin
        result <= modeQ ? frameQ[FRAME_W-2 -: DATA_W] : frameQ[DATA_W-1:0];
      end
    end
  end

endmodule

// File: rtl/adc_reader.sv
module adc_reader
  import adc_rd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned SCLK_HALF_NS  = 240,
  parameter int unsigned SETUP_NS      = 50,
  parameter int unsigned CONV_NS       = 7500,
  parameter int unsigned CS_HIGH_NS    = 240,
  parameter int unsigned ACQ_NS        = 1500,
  parameter int unsigned TIMEOUT_NS    = 10000,
  parameter int unsigned DATA_W        = 12,
  parameter int unsigned BYTE_W        = 8,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              byteMode,
  input  logic              pollEoc,
  input  logic              miso,
  output logic              sclk,
  output logic              csN,
  output logic              busy,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              frameErr,
  output logic              timeoutErr
);

  // Every interval rounds up so that the minimum timing always holds
  localparam int unsigned HALF_CYC    = maxU(cdivU(SCLK_HALF_NS, CLK_PERIOD_NS), SYNC_STAGES + 1);
  localparam int unsigned CONV_CYC    = maxU(cdivU(CONV_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned TIMEOUT_CYC = maxU(cdivU(TIMEOUT_NS, CLK_PERIOD_NS), 1);
  localparam int unsigned GUARD_CYC   = maxU(maxU(cdivU(CS_HIGH_NS, CLK_PERIOD_NS),
                                                  cdivU(SETUP_NS, CLK_PERIOD_NS)), 1);
  localparam int unsigned ACQ_CYC     = maxU(cdivU(ACQ_NS, CLK_PERIOD_NS), GUARD_CYC);

  rdStrobe_t strobe;
  logic      eocRise;
  logic      lastBit;

  adc_rd_ctrl #(
    .HALF_CYC   (HALF_CYC),
    .CONV_CYC   (CONV_CYC),
    .TIMEOUT_CYC(TIMEOUT_CYC),
    .GUARD_CYC  (GUARD_CYC),
    .ACQ_CYC    (ACQ_CYC)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .pollEoc   (pollEoc),
    .eocRise   (eocRise),
    .lastBit   (lastBit),
    .strobe    (strobe),
    .sclk      (sclk),
    .csN       (csN),
    .busy      (busy),
    .timeoutErr(timeoutErr)
  );

  adc_rd_datapath #(
    .DATA_W     (DATA_W),
    .BYTE_W     (BYTE_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .miso       (miso),
    .byteMode   (byteMode),
    .strobe     (strobe),
    .eocRise    (eocRise),
    .lastBit    (lastBit),
    .result     (result),
    .resultValid(resultValid),
    .frameErr   (frameErr)
  );

endmodule

// File: rtl/adc_reader_chk.sv
module adc_reader_chk #(
  parameter int unsigned HALF_CYC = 60
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic busy,
  input logic resultValid,
  input logic frameErr,
  input logic timeoutErr
);

  logic        sclkPrev;
  logic [15:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      runLen   <= '0;
    end else begin
      sclkPrev <= sclk;
      if (sclk != sclkPrev)     runLen <= '0;
      else if (runLen != '1)    runLen <= runLen + 16'd1;
    end
  end

  AST_CS_FALL_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(csN)) |-> (!sclk && !$past(sclk))); // R2
  AST_CS_LOW_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    !csN |-> busy); // R2
  AST_PHASE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (sclk != sclkPrev) |-> (runLen >= 16'(HALF_CYC - 1))); // R5
  AST_FRAME_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |-> resultValid); // R8
  AST_NO_SCLK_CS_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R9
  AST_CS_RISE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (csN && !$past(csN)) |-> !$past(sclk)); // R9
  AST_TIMEOUT_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (csN && !resultValid)); // R10
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid); // R11

endmodule

bind adc_reader adc_reader_chk #(.HALF_CYC(HALF_CYC)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .csN        (csN),
  .sclk       (sclk),
  .busy       (busy),
  .resultValid(resultValid),
  .frameErr   (frameErr),
  .timeoutErr (timeoutErr)
);

// File: tb/sim_adc_reader.sv
`timescale 1ns/1ps
module sim_adc_reader;

  localparam int P_HALF = 4;
  localparam int P_CONV = 60;
  localparam int P_CSH  = 10;
  localparam int P_ACQ  = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        byteMode = 1'b0;
  logic        pollEoc = 1'b0;
  logic        miso = 1'b1;
  logic        sclk, csN, busy, resultValid, frameErr, timeoutErr;
  logic [11:0] result;

  always #2 clk = ~clk;  // 250 MHz

  adc_reader #(
    .CLK_PERIOD_NS(4), .SCLK_HALF_NS(16), .SETUP_NS(8), .CONV_NS(240),
    .CS_HIGH_NS(40), .ACQ_NS(160), .TIMEOUT_NS(320)
  ) u0 (
    .clk(clk), .rstN(rstN), .start(start), .byteMode(byteMode), .pollEoc(pollEoc),
    .miso(miso), .sclk(sclk), .csN(csN), .busy(busy), .result(result),
    .resultValid(resultValid), .frameErr(frameErr), .timeoutErr(timeoutErr)
  );

  int nChecks = 0;
  int nErr    = 0;
  bit done    = 0;

  // converter model and bus monitor state
  logic [15:0] frame = 16'h8000;
  int  slvDelay = 5;
  bit  slvNever = 0;
  bit  ready = 0;
  int  idx = 0, scnt = 0;
  bit  prevSclk = 0, prevCs = 1;
  int  csFalls = 0, lastCsHigh = 0, csHighRun = 0;
  int  riseCnt = 0, earlyRise = 0, firstRiseAt = -1, sinceCs = 0;
  int  minHigh = 1000000, minLow = 1000000, runLen = 0;
  int  strayEdge = 0, csRiseBad = 0, validCnt = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevSclk = 0; prevCs = 1; miso = 1; ready = 0;
    end else begin
      if (prevCs && !csN) begin
        csFalls++; lastCsHigh = csHighRun; csHighRun = 0;
        riseCnt = 0; earlyRise = 0; firstRiseAt = -1; sinceCs = 0;
        minHigh = 1000000; minLow = 1000000; validCnt = 0;
      end else if (!csN) sinceCs++;
      if (csN) csHighRun++;
      if (!prevCs && csN && (sclk || prevSclk)) csRiseBad++;
      if (sclk != prevSclk) begin
        if (csN) strayEdge++;
        if (prevSclk) minHigh = (runLen < minHigh) ? runLen : minHigh;
        else          minLow  = (runLen < minLow)  ? runLen : minLow;
        runLen = 1;
        if (sclk) begin
          riseCnt++;
          if (firstRiseAt < 0) firstRiseAt = sinceCs;
          if (!ready) earlyRise++;
        end
      end else runLen++;
      if (resultValid) validCnt++;
      // converter: low while converting, marker on EOC, shift on falling sclk
      if (csN) begin
        miso = 1; ready = 0; idx = 0; scnt = 0;
      end else if (!ready) begin
        miso = 0; scnt++;
        if (!slvNever && scnt >= slvDelay) begin ready = 1; miso = frame[15]; end
      end else if (prevSclk && !sclk) begin
        idx++;
        miso = (idx < 16) ? frame[15-idx] : 1'b0;
      end
      prevSclk = sclk; prevCs = csN;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int expRises(input bit bm);
    return bm ? 16 : 13;
  endfunction

  function automatic bit expFrameErr(input bit bm, input bit badMk, input logic [2:0] tail);
    return bm && (badMk || (tail != 3'b000));
  endfunction

  bit firstXfer = 1;
  bit prevTimeout = 0;

  task automatic doXfer(input bit bm, input bit poll, input logic [11:0] data, input int dly,
                        input bit never, input logic [2:0] tail, input bit badMk, input bit extra);
    int fallsBefore;
    bit gotV, gotT, fe;
    logic [11:0] res;
    bool_wait: for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    frame = {~badMk, data, tail};
    slvDelay = dly;
    slvNever = never;
    fallsBefore = csFalls;
    @(negedge clk);
    byteMode = bm; pollEoc = poll; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    gotV = 0; gotT = 0; fe = 0; res = '0;
    for (int i = 0; i < 3000 && !gotV && !gotT; i++) begin
      @(negedge clk);
      start = (extra && (i == 20));
      if (resultValid) begin gotV = 1; res = result; fe = frameErr; end
      if (timeoutErr) gotT = 1;
    end
    start = 1'b0;
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    @(negedge clk);
    chk(csFalls - fallsBefore == 1, "R2", "csN falls per transaction", csFalls - fallsBefore, 1);
    if (!firstXfer)
      chk(lastCsHigh >= (prevTimeout ? P_ACQ : P_CSH), prevTimeout ? "R10" : "R9",
          "csN high time before fall", lastCsHigh, prevTimeout ? P_ACQ : P_CSH);
    chk(strayEdge == 0 && csRiseBad == 0, "R9", "sclk activity with csN high", strayEdge + csRiseBad, 0);
    if (poll && never) begin
      chk(gotT && !gotV, "R10", "timeout flagged without result", {gotT, gotV}, 2);
      chk(riseCnt == 0, "R10", "sclk rises on timeout", riseCnt, 0);
    end else begin
      chk(gotV && !gotT, "R11", "valid without timeout", {gotV, gotT}, 2);
      chk(validCnt == 1, "R11", "valid pulse count", validCnt, 1);
      if (bm) chk(riseCnt == expRises(bm), "R7", "byte framing rise count", riseCnt, expRises(bm));
      else    chk(riseCnt == expRises(bm), "R6", "continuous rise count", riseCnt, expRises(bm));
      chk(res == data, bm ? "R7" : "R6", "result", res, data);
      chk(fe == expFrameErr(bm, badMk, tail), "R8", "frameErr", fe, expFrameErr(bm, badMk, tail));
      chk(minHigh >= P_HALF && minLow >= P_HALF, "R5", "min sclk phase",
          (minHigh < minLow) ? minHigh : minLow, P_HALF);
      if (poll) begin
        chk(earlyRise == 0, "R3", "sclk before data rise", earlyRise, 0);
        chk(firstRiseAt <= dly + P_HALF + 8, "R3", "first rise after EOC", firstRiseAt, dly + P_HALF + 8);
      end else begin
        chk(firstRiseAt >= P_CONV, "R4", "first rise after fixed wait", firstRiseAt, P_CONV);
      end
    end
    prevTimeout = poll && never;
    firstXfer = 0;
  endtask

  initial begin
    int seedVal;
    seedVal = $urandom(32'h5EED1234);
    repeat (5) @(negedge clk);
    chk(csN === 1'b1 && sclk === 1'b0, "R1", "csN/sclk after reset", {csN, sclk}, 2);
    chk(busy === 1'b0 && resultValid === 1'b0 && frameErr === 1'b0 && timeoutErr === 1'b0,
        "R1", "status after reset", {busy, resultValid, frameErr, timeoutErr}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    // directed corners
    doXfer(0, 1, 12'hFFF, 3,  0, 3'b000, 0, 0);  // R6 all ones, fast EOC
    doXfer(0, 1, 12'h000, 25, 0, 3'b000, 0, 0);  // R6 all zeros
    doXfer(1, 1, 12'hA5C, 10, 0, 3'b000, 0, 0);  // R7 byte framing
    doXfer(1, 0, 12'h123, 12, 0, 3'b000, 0, 0);  // R4 fixed wait
    doXfer(1, 1, 12'h3C7, 8,  0, 3'b101, 0, 0);  // R8 bad padding
    doXfer(1, 0, 12'h9E1, 6,  0, 3'b000, 1, 0);  // R8 marker 0
    doXfer(0, 1, 12'h5A5, 8,  0, 3'b111, 0, 0);  // R8 continuous ignores padding
    doXfer(0, 1, 12'h777, 5,  1, 3'b000, 0, 0);  // R10 timeout
    doXfer(1, 1, 12'h0F0, 9,  0, 3'b000, 0, 1);  // R2 start while busy, after timeout guard
    for (int n = 0; n < 24; n++) begin
      bit bm, poll, never, badMk, extra;
      logic [2:0] tail;
      bm    = 1'($urandom % 2);
      poll  = 1'($urandom % 2);
      never = poll && ($urandom % 8 == 0);
      badMk = !poll && ($urandom % 6 == 0);
      tail  = ($urandom % 4 == 0) ? 3'($urandom % 8) : 3'b000;
      extra = ($urandom % 3 == 0);
      doXfer(bm, poll, 12'($urandom % 4096), 2 + int'($urandom % 28), never, tail, badMk, extra);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

endmodule